// File: doc/BRIEF.md
# Asynchronous Parallel Host Port Sequencer

This block is the master side of an 8-bit asynchronous host port on a peripheral DSP. The port has an active-low chip select, separate active-low read and write strobes, an address bus and a data bus, which is split here into an input, an output and an output enable. On the system side, a one-cycle valid pulse starts a single read or write. The block answers with a one-cycle done pulse and, on reads, the captured byte.

Each access runs through five phases: idle, setup, strobe, hold and recovery. A down counter times each phase in system-clock cycles. The setup and hold lengths are fixed nanosecond values. The strobe width and the recovery gap scale with the peripheral's DSP clock, whose period becomes much shorter once the peripheral has booted. Both cycle sets are rounded up from picosecond parameters when the design is elaborated. The boot-done input, sampled when a request is accepted, picks the set used for that access and for the recovery that follows it.

Top module: `host_port_master`

## Requirements
- R1: While reset is held, and after it is released, chip select and both strobes are high, the data output enable is low, done is low and ready is high.
- R2: A request is accepted only on a clock edge where `req_valid_i` and `req_ready_o` are both high. A valid pulse while busy starts no strobe on the port.
- R3: Chip select is low with the address driven for at least one cycle before a strobe falls. Chip select stays low with the address unchanged on the first cycle after the strobe rises. The address does not change while chip select is low.
- R4: A read holds `per_rd_no` low for exactly ceil((Tdclk + 10 ns) / Tsys) cycles. With the defaults this is 6 cycles when boot_done=0 (Tdclk 100 ns) and 2 cycles when boot_done=1 (Tdclk 16.7 ns).
- R5: A write holds `per_wr_no` low for the same count as R4. Throughout the strobe, the output enable is high and `per_data_o` carries the request's write data.
- R6: On a read, the byte present on `per_data_i` in the last strobe cycle appears on `rdata_o`. `done_o` is high for exactly one cycle, on the cycle in which the strobe is released. Writes also give a single done pulse at that point.
- R7: From a strobe rising to the next strobe falling, at least ceil((2*Tdclk + 10 ns) / Tsys) cycles pass: 11 cycles pre-boot and 3 post-boot. This holds for every read/write pairing and uses the timing set of the earlier access.
- R8: The value of `boot_done_i` at acceptance sets the timing for the whole access. Later changes to it have no effect until the next acceptance.
- R9: The read and write strobes are never low together, and a strobe is low only while chip select is low.
- R10: The data output enable is high only while chip select is low and the read strobe is high. It is never high during reads, idle or recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_done_i | input | 1 | Peripheral has booted; selects the post-boot timing set |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Idle, can accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| per_cs_no | output | 1 | Peripheral chip select, active low |
| per_rd_no | output | 1 | Read strobe, active low |
| per_wr_no | output | 1 | Write strobe, active low |
| per_addr_o | output | ADDR_W | Peripheral address |
| per_data_o | output | DATA_W | Data driven toward the peripheral |
| per_data_oe_o | output | 1 | Output enable for per_data_o |
| per_data_i | input | DATA_W | Data from the peripheral |

## Verification
The bench uses the default parameters: a 20 ns system period, a 100 ns pre-boot DSP clock and a 16.7 ns post-boot DSP clock. These give strobe widths of 6 and 2 cycles and recovery gaps of 11 and 3 cycles. Because the two sets differ so much, the bench can tell which set each access used. The 26.7 ns post-boot strobe must round up to 2 cycles, so a rounding error shows up directly as a pulse-width failure. Toggling boot_done between and during accesses covers all four read/write pairings under both sets, and also covers a flag change in mid-access.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV
  } phase_e;

  // ceil(ps/per), at least one cycle
  function automatic int cyc_ceil(input int ps, input int per);
    int r;
    r = (ps + per - 1) / per;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hpm_timing.sv
module hpm_timing #(
  parameter int CNT_W      = 4,
  parameter int PRE_PULSE  = 6,
  parameter int POST_PULSE = 2,
  parameter int PRE_REC    = 11,
  parameter int POST_REC   = 3
) (
  input  logic             boot_i,
  output logic [CNT_W-1:0] pulse_o,
  output logic [CNT_W-1:0] rec_o
);
  localparam logic [CNT_W-1:0] PRE_P  = CNT_W'(PRE_PULSE);
  localparam logic [CNT_W-1:0] POST_P = CNT_W'(POST_PULSE);
  localparam logic [CNT_W-1:0] PRE_R  = CNT_W'(PRE_REC);
  localparam logic [CNT_W-1:0] POST_R = CNT_W'(POST_REC);

  assign pulse_o = boot_i ? POST_P : PRE_P;
  assign rec_o   = boot_i ? POST_R : PRE_R;
endmodule

// File: rtl/hpm_seq.sv
module hpm_seq
  import hpm_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] pulse_cyc_i,
  input  logic [CNT_W-1:0] rec_cyc_i,
  output phase_e           phase_q_o,
  output phase_e           phase_d_o,
  output logic             capture_o,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_N   = CNT_W'(HOLD_CYC);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = last ? cnt_q : cnt_q - 1'b1;
    unique case (phase_q)
      PH_IDLE:   if (start_i) begin phase_d = PH_SETUP;  cnt_d = SETUP_LD; end
      PH_SETUP:  if (last)    begin phase_d = PH_STROBE; cnt_d = pulse_cyc_i - 1'b1; end
      PH_STROBE: if (last)    begin phase_d = PH_HOLD;   cnt_d = HOLD_LD; end
      // recovery counted from strobe release, hold cycles included
      PH_HOLD:   if (last)    begin phase_d = PH_RECOV;  cnt_d = rec_cyc_i - HOLD_N - 1'b1; end
      PH_RECOV:  if (last)    begin phase_d = PH_IDLE; end
      default:   begin phase_d = PH_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_q_o = phase_q;
  assign phase_d_o = phase_d;
  assign capture_o = (phase_q == PH_STROBE) && last;
  assign ready_o   = (phase_q == PH_IDLE);

  assert_start_only_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |=> (phase_q != PH_SETUP) || ($past(phase_q) == PH_SETUP && $past(cnt_q) != '0));
endmodule

// File: rtl/host_port_master.sv
module host_port_master
  import hpm_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int DATA_W         = 8,
  parameter int SYS_PS         = 20000,
  parameter int PRE_DCLK_PS    = 100000,
  parameter int POST_DCLK_PS   = 16700,
  parameter int ADDR_SETUP_PS  = 5000,
  parameter int ADDR_HOLD_PS   = 5000,
  parameter int PULSE_EXTRA_PS = 10000,
  parameter int REC_EXTRA_PS   = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_done_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              per_cs_no,
  output logic              per_rd_no,
  output logic              per_wr_no,
  output logic [ADDR_W-1:0] per_addr_o,
  output logic [DATA_W-1:0] per_data_o,
  output logic              per_data_oe_o,
  input  logic [DATA_W-1:0] per_data_i
);
  localparam int SETUP_CYC  = cyc_ceil(ADDR_SETUP_PS, SYS_PS);
  localparam int HOLD_CYC   = cyc_ceil(ADDR_HOLD_PS, SYS_PS);
  localparam int PRE_PULSE  = cyc_ceil(PRE_DCLK_PS + PULSE_EXTRA_PS, SYS_PS);
  localparam int POST_PULSE = cyc_ceil(POST_DCLK_PS + PULSE_EXTRA_PS, SYS_PS);
  localparam int PRE_REC    = max2(cyc_ceil(2 * PRE_DCLK_PS + REC_EXTRA_PS, SYS_PS), HOLD_CYC + 1);
  localparam int POST_REC   = max2(cyc_ceil(2 * POST_DCLK_PS + REC_EXTRA_PS, SYS_PS), HOLD_CYC + 1);
  localparam int CNT_MAX    = max2(max2(PRE_PULSE, POST_PULSE), max2(max2(PRE_REC, POST_REC),
                                   max2(SETUP_CYC, HOLD_CYC)));
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  logic              start, capture, ready;
  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  pulse_cyc, rec_cyc;
  logic              we_q, boot_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              cs_n_q, rd_n_q, wr_n_q, oe_q, done_q;

  assign start = req_valid_i && ready;

  hpm_timing #(
    .CNT_W(CNT_W), .PRE_PULSE(PRE_PULSE), .POST_PULSE(POST_PULSE),
    .PRE_REC(PRE_REC), .POST_REC(POST_REC)
  ) u_timing (
    .boot_i (boot_q),
    .pulse_o(pulse_cyc),
    .rec_o  (rec_cyc)
  );

  hpm_seq #(
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .pulse_cyc_i(pulse_cyc),
    .rec_cyc_i  (rec_cyc),
    .phase_q_o  (phase_q),
    .phase_d_o  (phase_d),
    .capture_o  (capture),
    .ready_o    (ready)
  );

  // request latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      boot_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      we_q    <= req_write_i;
      boot_q  <= boot_done_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  logic nx_we;
  assign nx_we = start ? req_write_i : we_q;

  // pins registered from next phase: glitch-free strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q <= 1'b1;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      cs_n_q <= (phase_d == PH_IDLE) || (phase_d == PH_RECOV);
      rd_n_q <= !((phase_d == PH_STROBE) && !nx_we);
      wr_n_q <= !((phase_d == PH_STROBE) && nx_we);
      oe_q   <= nx_we && ((phase_d == PH_SETUP) || (phase_d == PH_STROBE) || (phase_d == PH_HOLD));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= capture;
      if (capture && !we_q) rdata_q <= per_data_i;
    end
  end

  assign req_ready_o   = ready;
  assign done_o        = done_q;
  assign rdata_o       = rdata_q;
  assign per_cs_no     = cs_n_q;
  assign per_rd_no     = rd_n_q;
  assign per_wr_no     = wr_n_q;
  assign per_addr_o    = addr_q;
  assign per_data_o    = wdata_q;
  assign per_data_oe_o = oe_q;

  // ---- interface checks ----
  logic             stb_hi;
  logic [7:0]       chk_low, chk_gap;
  logic [CNT_W-1:0] chk_prev_rec;
  assign stb_hi = per_rd_no && per_wr_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_low      <= '0;
      chk_gap      <= 8'hff;
      chk_prev_rec <= '0;
    end else begin
      chk_low <= stb_hi ? 8'd0 : chk_low + 8'd1;
      chk_gap <= !stb_hi ? 8'd0 : (chk_gap == 8'hff ? chk_gap : chk_gap + 8'd1);
      if (!stb_hi) chk_prev_rec <= rec_cyc;
    end
  end

  assert_idle_pins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (per_rd_no && per_wr_no && !per_data_oe_o));
  assert_strobe_in_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!per_rd_no || !per_wr_no) |-> !per_cs_no);
  assert_one_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!per_rd_no && !per_wr_no));
  assert_oe_write_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_data_oe_o |-> (per_rd_no && !per_cs_no));
  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!per_cs_no && $past(!per_cs_no)) |-> $stable(per_addr_o));
  assert_cs_before_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stb_hi) |-> $past(!per_cs_no));
  assert_pulse_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stb_hi) |-> (chk_low == 8'(pulse_cyc)));
  assert_recovery_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stb_hi) |-> (chk_gap >= 8'(chk_prev_rec)));
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/host_port_master_test.sv
module host_port_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       ready, done;
  logic [7:0] rdata;
  logic       cs_n, rd_n, wr_n, oe;
  logic [3:0] p_addr;
  logic [7:0] p_dout, p_din;

  always #10 clk = ~clk;

  host_port_master uut (
    .clk_i(clk), .rst_ni(rst_n), .boot_done_i(boot),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(ready), .done_o(done), .rdata_o(rdata),
    .per_cs_no(cs_n), .per_rd_no(rd_n), .per_wr_no(wr_n), .per_addr_o(p_addr),
    .per_data_o(p_dout), .per_data_oe_o(oe), .per_data_i(p_din)
  );

  function automatic logic [7:0] rd_val(input logic [3:0] a);
    return {4'hA, a} ^ 8'h3C;
  endfunction
  // peripheral drives data only while read strobe is low
  assign p_din = (!cs_n && !rd_n) ? rd_val(p_addr) : 8'h00;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int dclk_ps(input logic b);
    return b ? 16700 : 100000;
  endfunction
  function automatic int exp_pulse(input logic b);
    return ceil_div(dclk_ps(b) + 10000, 20000);
  endfunction
  function automatic int exp_rec(input logic b);
    return ceil_div(2 * dclk_ps(b) + 10000, 20000);
  endfunction

  typedef struct {
    logic       we;
    logic [3:0] addr;
    logic [7:0] data;
    logic       boot;
  } exp_t;
  exp_t q[$];

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic access(input logic we, input logic [3:0] a, input logic [7:0] d, input logic b);
    exp_t e;
    @(negedge clk);
    while (!ready) @(negedge clk);
    e.we = we; e.addr = a; e.data = d; e.boot = b;
    q.push_back(e);
    req_write = we; req_addr = a; req_wdata = d; boot = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / peripheral timing checker
  bit   prev_lo = 0, have_prev = 0, last_boot = 0, last_we = 0;
  int   low_cnt = 0, gap_cnt = 0, setup_cnt = 0;
  logic [7:0] wseen = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      bit lo;
      exp_t e;
      lo = !rd_n || !wr_n;
      if (oe) check(!cs_n && rd_n, "R10 oe outside write", {cs_n, rd_n}, 2'b01);
      if (lo && !prev_lo) begin
        check(setup_cnt >= 1, "R3 cs/addr setup", setup_cnt, 1);
        if (have_prev) check(gap_cnt >= exp_rec(last_boot), "R7 recovery gap", gap_cnt, exp_rec(last_boot));
        low_cnt = 1;
        last_we = !wr_n;
      end else if (lo) low_cnt++;
      if (!wr_n) begin
        wseen = p_dout;
        if (q.size() != 0) check(oe && p_dout == q[0].data, "R5 write data driven", {oe, p_dout}, {1'b1, q[0].data});
      end
      if (!lo && prev_lo) begin
        if (q.size() == 0) check(0, "R2 unexpected strobe", 1, 0);
        else begin
          e = q.pop_front();
          check(last_we == e.we, "R5 access kind", last_we, e.we);
          check(low_cnt == exp_pulse(e.boot), e.we ? "R5 write pulse" : "R4 read pulse / R8 boot set",
                low_cnt, exp_pulse(e.boot));
          check(!cs_n && p_addr == e.addr, "R3 hold after strobe", {cs_n, p_addr}, {1'b0, e.addr});
          check(done, "R6 done pulse", done, 1);
          if (e.we) check(wseen == e.data, "R5 write data", wseen, e.data);
          else check(rdata == rd_val(e.addr), "R6 read data", rdata, rd_val(e.addr));
          last_boot = e.boot;
          have_prev = 1;
        end
        gap_cnt = 1;
      end else if (!lo) gap_cnt++;
      else if (done) check(0, "R6 stray done", 1, 0);
      if (cs_n) setup_cnt = 0;
      else if (!lo) setup_cnt++;
      prev_lo = lo;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n && rd_n && wr_n && !oe && !done && ready, "R1 reset state",
          {cs_n, rd_n, wr_n, oe, done, ready}, 6'b111001);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && rd_n && wr_n && !oe && ready, "R1 after release", {cs_n, rd_n, wr_n, oe, ready}, 5'b11101);

    // pre-boot: all four pairings
    access(0, 4'h0, 8'h00, 0);
    access(0, 4'hF, 8'h00, 0);
    access(1, 4'h3, 8'hA5, 0);
    access(1, 4'hF, 8'hFF, 0);
    access(0, 4'h7, 8'h00, 0);
    // post-boot: all four pairings, boundary data
    access(0, 4'h1, 8'h00, 1);
    access(1, 4'h0, 8'h00, 1);
    access(1, 4'hE, 8'hFF, 1);
    access(0, 4'hE, 8'h00, 1);
    access(0, 4'h5, 8'h00, 1);
    // R8: boot flag flips mid-access, timing stays pre-boot
    access(1, 4'h9, 8'h5A, 0);
    boot = 1'b1;
    // R2: valid while busy must be ignored
    req_write = 1'b0; req_addr = 4'hC; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    boot = 1'b0;
    // post-to-pre and pre-to-post transitions
    access(0, 4'h2, 8'h00, 1);
    access(1, 4'h4, 8'h3C, 0);
    access(0, 4'hB, 8'h00, 1);
    while (q.size() != 0 || !ready) @(negedge clk);
    repeat (20) @(negedge clk);
    check(q.size() == 0 && ready && cs_n, "R2 no extra access", q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule